// File: doc/BRIEF.md
# Breakpoint and Code Remap Comparator Unit

This block watches two address streams headed for code space and compares each one against a bank of programmable comparators. The first stream carries instruction fetch addresses and the second carries literal data loads. Six comparators serve the fetch stream. Each of them is set either to raise a breakpoint or to redirect the fetch into a remap table in system space. Two more comparators serve the literal stream, and they can only redirect. The debug halt logic and the bus fabric sit outside the block: the first consumes the breakpoint flag, and the second consumes the possibly rewritten address.

Configuration arrives through a write-only register port. A register select picks one of three targets: a control word holding the global enable, the remap table base, or one comparator slot. Every result is registered, so the flags and the outgoing address for an access appear one clock after that access is presented.

Top module: `fpbUnit`

## Requirements
- R1: After a synchronous reset (`rst` high), all output flags and output valids are 0, and every configuration field is cleared, so no access matches until software programs the block.
- R2: While the global enable (select 0, bit 0) is 0, no comparator matches on either stream.
- R3: A fetch comparator in mode 00 that matches a valid fetch sets `ifRemap`. The outgoing address is then {3'b001, base field, comparator index (3 bits), fetch address bits [1:0]}. The base field comes from select 1, bits [28:5].
- R4: A fetch comparator in a breakpoint mode (01 lower halfword, 10 upper halfword, 11 both) sets `bkpt`, drives `bkptHalf` equal to its mode, keeps `ifRemap` at 0 and passes the fetch address through unchanged.
- R5: Literal comparators 6 and 7 always remap when they match, using indices 6 and 7 in the target address. Their mode bits are ignored.
- R6: Fetch comparators (0 to 5) never match literal accesses, and literal comparators never match fetches.
- R7: An address with bits [31:29] not equal to 0 (outside code space) never matches, even when its bits [28:2] equal a compare address.
- R8: When several comparators of one stream match, the lowest-numbered one alone decides the result, whether it is set to breakpoint or to remap.
- R9: Each output valid equals its input valid from one cycle earlier. When the input valid was 0, the remap and breakpoint flags are 0.
- R10: A comparator slot (select 2+k: bit 0 enable, bits [28:2] word address, bits [31:30] mode) whose enable bit is 0 never matches. A write to selects 10 to 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 4 | Configuration register select |
| cfgWdata | input | 32 | Configuration write data |
| ifValid | input | 1 | Fetch address valid |
| ifAddr | input | 32 | Fetch address |
| litValid | input | 1 | Literal access valid |
| litAddr | input | 32 | Literal access address |
| ifOutValid | output | 1 | Registered fetch valid |
| ifOutAddr | output | 32 | Fetch address after a possible remap |
| ifRemap | output | 1 | Fetch was redirected |
| bkpt | output | 1 | Breakpoint request |
| bkptHalf | output | 2 | Halfwords covered by the breakpoint (bit 0 lower, bit 1 upper) |
| litOutValid | output | 1 | Registered literal valid |
| litOutAddr | output | 32 | Literal address after a possible remap |
| litRemap | output | 1 | Literal access was redirected |

## Verification
Some properties are checked on every cycle. The assertions cover the one-cycle valid alignment, and that the breakpoint and remap flags are never both set. They also check that addresses outside code space are never flagged, that remapped addresses land in system space with a table index of the right comparator type, and that the low two address bits pass through unchanged. Other behaviour needs the programmed configuration, which the assertions do not see. This covers which comparator wins under overlap, the exact target address, the halfword selection, the effect of the global and per-slot enables, and the fact that writes to unused selects change nothing. The bench's directed scenarios and its seeded random runs check these against a shadow model of the registers.

// File: rtl/fpbPkg.sv
package fpbPkg;
  localparam int NUM_INSN_DEF = 6;
  localparam int NUM_LIT_DEF  = 2;
  localparam int NUM_CMP_DEF  = NUM_INSN_DEF + NUM_LIT_DEF;
  localparam int IDX_W        = $clog2(NUM_CMP_DEF);
  localparam int REGION_W     = 3;

  typedef enum logic [1:0] {
    MODE_REMAP   = 2'b00,
    MODE_BP_LO   = 2'b01,
    MODE_BP_HI   = 2'b10,
    MODE_BP_BOTH = 2'b11
  } cmpMode_e;

  typedef struct packed {
    logic             ifRemap;
    logic             ifBkpt;
    logic [1:0]       ifHalf;
    logic [IDX_W-1:0] ifIdx;
    logic             litRemap;
    logic [IDX_W-1:0] litIdx;
  } matchStb_t;
endpackage

// File: rtl/fpbCmp.sv
module fpbCmp #(
  parameter int WORD_W   = 27,
  parameter int REGION_W = 3
) (
  input  logic                armed,
  input  logic [REGION_W-1:0] region,
  input  logic [WORD_W-1:0]   word,
  input  logic [WORD_W-1:0]   target,
  output logic                hit
);
  // code space is the region whose top bits are all zero
  assign hit = armed && (region == '0) && (word == target);
endmodule

// File: rtl/fpbCtrl.sv
module fpbCtrl
  import fpbPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_INSN = NUM_INSN_DEF,
  parameter int NUM_LIT  = NUM_LIT_DEF,
  parameter int SEL_W    = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfgWe,
  input  logic [SEL_W-1:0]                   cfgSel,
  input  logic [ADDR_W-1:0]                  cfgWdata,
  input  logic                               ifValid,
  input  logic [ADDR_W-3:0]                  ifWord,
  input  logic                               litValid,
  input  logic [ADDR_W-3:0]                  litWord,
  output matchStb_t                          stb,
  output logic [ADDR_W-REGION_W-1:IDX_W+2]   baseHi
);
  localparam int NUM_CMP  = NUM_INSN + NUM_LIT;
  localparam int WORD_W   = ADDR_W - 2 - REGION_W;
  localparam int BASE_LSB = IDX_W + 2;
  localparam int SEL_CMP0 = 2;

  logic                    globalEn;
  logic [NUM_CMP-1:0]      cmpEn;
  logic [WORD_W-1:0]       cmpAddr [NUM_CMP];
  cmpMode_e                cmpMode [NUM_INSN];
  logic [NUM_CMP-1:0]      hitVec;

  logic unusedCfg;
  assign unusedCfg = ^{cfgWdata[ADDR_W-REGION_W], cfgWdata[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      globalEn <= 1'b0;
      baseHi   <= '0;
      cmpEn    <= '0;
      for (int k = 0; k < NUM_CMP; k++) cmpAddr[k] <= '0;
      for (int k = 0; k < NUM_INSN; k++) cmpMode[k] <= MODE_REMAP;
    end else if (cfgWe) begin
      if (cfgSel == SEL_W'(0)) globalEn <= cfgWdata[0];
      if (cfgSel == SEL_W'(1)) baseHi <= cfgWdata[ADDR_W-REGION_W-1:BASE_LSB];
      for (int k = 0; k < NUM_CMP; k++) begin
        if (cfgSel == SEL_W'(k + SEL_CMP0)) begin
          cmpEn[k]   <= cfgWdata[0];
          cmpAddr[k] <= cfgWdata[ADDR_W-REGION_W-1:2];
        end
      end
      for (int k = 0; k < NUM_INSN; k++) begin
        if (cfgSel == SEL_W'(k + SEL_CMP0))
          cmpMode[k] <= cmpMode_e'(cfgWdata[ADDR_W-1:ADDR_W-2]);
      end
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : gCmp
    if (g < NUM_INSN) begin : gInsn
      fpbCmp #(.WORD_W(WORD_W), .REGION_W(REGION_W)) u_cmp (
        .armed (globalEn & cmpEn[g]),
        .region(ifWord[ADDR_W-3:WORD_W]),
        .word  (ifWord[WORD_W-1:0]),
        .target(cmpAddr[g]),
        .hit   (hitVec[g])
      );
    end else begin : gLit
      fpbCmp #(.WORD_W(WORD_W), .REGION_W(REGION_W)) u_cmp (
        .armed (globalEn & cmpEn[g]),
        .region(litWord[ADDR_W-3:WORD_W]),
        .word  (litWord[WORD_W-1:0]),
        .target(cmpAddr[g]),
        .hit   (hitVec[g])
      );
    end
  end

  logic             ifFound, litFound;
  logic [IDX_W-1:0] ifSel, litSel;
  cmpMode_e         selMode;

  // descending scan: the last assignment is the lowest matching index
  always_comb begin
    ifFound = 1'b0;
    ifSel   = '0;
    selMode = MODE_REMAP;
    for (int k = NUM_INSN - 1; k >= 0; k--) begin
      if (hitVec[k]) begin
        ifFound = 1'b1;
        ifSel   = IDX_W'(k);
        selMode = cmpMode[k];
      end
    end
    litFound = 1'b0;
    litSel   = '0;
    for (int j = NUM_LIT - 1; j >= 0; j--) begin
      if (hitVec[NUM_INSN + j]) begin
        litFound = 1'b1;
        litSel   = IDX_W'(NUM_INSN + j);
      end
    end
  end

  always_comb begin
    stb.ifRemap  = ifValid && ifFound && (selMode == MODE_REMAP);
    stb.ifBkpt   = ifValid && ifFound && (selMode != MODE_REMAP);
    stb.ifHalf   = stb.ifBkpt ? selMode : 2'b00;
    stb.ifIdx    = ifSel;
    stb.litRemap = litValid && litFound;
    stb.litIdx   = litSel;
  end
endmodule

// File: rtl/fpbPath.sv
module fpbPath
  import fpbPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  matchStb_t                         stb,
  input  logic [ADDR_W-REGION_W-1:IDX_W+2]  baseHi,
  input  logic                              ifValid,
  input  logic [ADDR_W-1:0]                 ifAddr,
  input  logic                              litValid,
  input  logic [ADDR_W-1:0]                 litAddr,
  output logic                              ifOutValid,
  output logic [ADDR_W-1:0]                 ifOutAddr,
  output logic                              ifRemap,
  output logic                              bkpt,
  output logic [1:0]                        bkptHalf,
  output logic                              litOutValid,
  output logic [ADDR_W-1:0]                 litOutAddr,
  output logic                              litRemap
);
  localparam logic [REGION_W-1:0] SYS_REGION = REGION_W'(1);

  logic [ADDR_W-1:0] ifTarget, litTarget;
  assign ifTarget  = {SYS_REGION, baseHi, stb.ifIdx, ifAddr[1:0]};
  assign litTarget = {SYS_REGION, baseHi, stb.litIdx, litAddr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ifOutValid  <= 1'b0;
      ifOutAddr   <= '0;
      ifRemap     <= 1'b0;
      bkpt        <= 1'b0;
      bkptHalf    <= 2'b00;
      litOutValid <= 1'b0;
      litOutAddr  <= '0;
      litRemap    <= 1'b0;
    end else begin
      ifOutValid  <= ifValid;
      ifOutAddr   <= stb.ifRemap ? ifTarget : ifAddr;
      ifRemap     <= stb.ifRemap;
      bkpt        <= stb.ifBkpt;
      bkptHalf    <= stb.ifHalf;
      litOutValid <= litValid;
      litOutAddr  <= stb.litRemap ? litTarget : litAddr;
      litRemap    <= stb.litRemap;
    end
  end
endmodule

// File: rtl/fpbUnit.sv
module fpbUnit
  import fpbPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_INSN = NUM_INSN_DEF,
  parameter int NUM_LIT  = NUM_LIT_DEF,
  parameter int SEL_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              ifValid,
  input  logic [ADDR_W-1:0] ifAddr,
  input  logic              litValid,
  input  logic [ADDR_W-1:0] litAddr,
  output logic              ifOutValid,
  output logic [ADDR_W-1:0] ifOutAddr,
  output logic              ifRemap,
  output logic              bkpt,
  output logic [1:0]        bkptHalf,
  output logic              litOutValid,
  output logic [ADDR_W-1:0] litOutAddr,
  output logic              litRemap
);
  matchStb_t                        stb;
  logic [ADDR_W-REGION_W-1:IDX_W+2] baseHi;

  fpbCtrl #(.ADDR_W(ADDR_W), .NUM_INSN(NUM_INSN), .NUM_LIT(NUM_LIT), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .ifValid(ifValid), .ifWord(ifAddr[ADDR_W-1:2]),
    .litValid(litValid), .litWord(litAddr[ADDR_W-1:2]),
    .stb(stb), .baseHi(baseHi)
  );

  fpbPath #(.ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rst(rst), .stb(stb), .baseHi(baseHi),
    .ifValid(ifValid), .ifAddr(ifAddr), .litValid(litValid), .litAddr(litAddr),
    .ifOutValid(ifOutValid), .ifOutAddr(ifOutAddr), .ifRemap(ifRemap),
    .bkpt(bkpt), .bkptHalf(bkptHalf),
    .litOutValid(litOutValid), .litOutAddr(litOutAddr), .litRemap(litRemap)
  );
endmodule

// File: rtl/fpbChk.sv
module fpbChk #(
  parameter int ADDR_W   = 32,
  parameter int NUM_INSN = 6,
  parameter int IDX_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ifValid,
  input logic [ADDR_W-1:0] ifAddr,
  input logic              litValid,
  input logic [ADDR_W-1:0] litAddr,
  input logic              ifOutValid,
  input logic [ADDR_W-1:0] ifOutAddr,
  input logic              ifRemap,
  input logic              bkpt,
  input logic [1:0]        bkptHalf,
  input logic              litOutValid,
  input logic [ADDR_W-1:0] litOutAddr,
  input logic              litRemap
);
  // R9
  if_valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ifValid |=> ifOutValid);
  // R9
  if_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ifValid |=> (!ifOutValid && !ifRemap && !bkpt));
  // R9
  lit_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !litValid |=> (!litOutValid && !litRemap));
  // R4
  bkpt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    bkpt |-> (!ifRemap && bkptHalf != 2'b00));
  // R4
  half_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bkpt |-> bkptHalf == 2'b00);
  // R7
  if_region_chk: assert property (@(posedge clk) disable iff (rst)
    (ifValid && ifAddr[ADDR_W-1:ADDR_W-3] != 3'b000) |=> (!ifRemap && !bkpt));
  // R7
  lit_region_chk: assert property (@(posedge clk) disable iff (rst)
    (litValid && litAddr[ADDR_W-1:ADDR_W-3] != 3'b000) |=> !litRemap);
  // R3
  if_target_chk: assert property (@(posedge clk) disable iff (rst)
    ifRemap |-> (ifOutAddr[ADDR_W-1:ADDR_W-3] == 3'b001 &&
                 ifOutAddr[IDX_W+1:2] < IDX_W'(NUM_INSN)));
  // R3
  if_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ifValid |=> ifOutAddr[1:0] == $past(ifAddr[1:0]));
  // R5
  lit_target_chk: assert property (@(posedge clk) disable iff (rst)
    litRemap |-> (litOutAddr[ADDR_W-1:ADDR_W-3] == 3'b001 &&
                  litOutAddr[IDX_W+1:2] >= IDX_W'(NUM_INSN)));
endmodule

bind fpbUnit fpbChk #(.ADDR_W(ADDR_W), .NUM_INSN(NUM_INSN), .IDX_W(fpbPkg::IDX_W)) u_chk (
  .clk(clk), .rst(rst), .ifValid(ifValid), .ifAddr(ifAddr),
  .litValid(litValid), .litAddr(litAddr),
  .ifOutValid(ifOutValid), .ifOutAddr(ifOutAddr), .ifRemap(ifRemap),
  .bkpt(bkpt), .bkptHalf(bkptHalf),
  .litOutValid(litOutValid), .litOutAddr(litOutAddr), .litRemap(litRemap)
);

// File: tb/tb_fpbUnit.sv
module tb_fpbUnit;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfgWe;
  logic [3:0]  cfgSel;
  logic [31:0] cfgWdata;
  logic        ifValid, litValid;
  logic [31:0] ifAddr, litAddr;
  logic        ifOutValid, ifRemap, bkpt, litOutValid, litRemap;
  logic [31:0] ifOutAddr, litOutAddr;
  logic [1:0]  bkptHalf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fpbUnit dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .ifValid(ifValid), .ifAddr(ifAddr), .litValid(litValid), .litAddr(litAddr),
    .ifOutValid(ifOutValid), .ifOutAddr(ifOutAddr), .ifRemap(ifRemap),
    .bkpt(bkpt), .bkptHalf(bkptHalf),
    .litOutValid(litOutValid), .litOutAddr(litOutAddr), .litRemap(litRemap)
  );

  // shadow configuration
  logic        sG;
  logic [23:0] sBase;
  logic        sEn   [8];
  logic [26:0] sWord [8];
  logic [1:0]  sMode [6];

  logic        eIfV, eIfR, eBk, eLitV, eLitR;
  logic [1:0]  eHalf;
  logic [31:0] eIfA, eLitA;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic shadowReset();
    sG = 0; sBase = '0;
    for (int k = 0; k < 8; k++) begin sEn[k] = 0; sWord[k] = '0; end
    for (int k = 0; k < 6; k++) sMode[k] = 2'b00;
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    cfgWe = 1; cfgSel = sel; cfgWdata = d; ifValid = 0; litValid = 0;
    @(negedge clk);
    cfgWe = 0;
    if (sel == 0) sG = d[0];
    else if (sel == 1) sBase = d[28:5];
    else if (sel <= 9) begin
      sEn[sel-2] = d[0];
      sWord[sel-2] = d[28:2];
      if (sel - 2 < 6) sMode[sel-2] = d[31:30];
    end
  endtask

  function automatic logic [31:0] slot(input logic [1:0] mode, input logic [31:0] a, input logic en);
    return {mode, 1'b0, a[28:2], 1'b0, en};
  endfunction

  task automatic model(input logic iv, input logic [31:0] ia, input logic lv, input logic [31:0] la);
    bit done;
    eIfV = iv; eIfR = 0; eBk = 0; eHalf = 0; eIfA = ia;
    eLitV = lv; eLitR = 0; eLitA = la;
    done = 0;
    if (iv && sG && ia[31:29] == 3'b000) begin
      for (int k = 0; k < 6; k++) begin
        if (!done && sEn[k] && sWord[k] == ia[28:2]) begin
          done = 1;
          if (sMode[k] == 2'b00) begin
            eIfR = 1; eIfA = {3'b001, sBase, 3'(k), ia[1:0]};
          end else begin
            eBk = 1; eHalf = sMode[k];
          end
        end
      end
    end
    done = 0;
    if (lv && sG && la[31:29] == 3'b000) begin
      for (int k = 6; k < 8; k++) begin
        if (!done && sEn[k] && sWord[k] == la[28:2]) begin
          done = 1; eLitR = 1; eLitA = {3'b001, sBase, 3'(k), la[1:0]};
        end
      end
    end
  endtask

  task automatic step(input logic iv, input logic [31:0] ia, input logic lv, input logic [31:0] la, input string req);
    model(iv, ia, lv, la);
    ifValid = iv; ifAddr = ia; litValid = lv; litAddr = la;
    @(negedge clk);
    chk(req, "ifOutValid", 32'(ifOutValid), 32'(eIfV));
    chk(req, "ifRemap", 32'(ifRemap), 32'(eIfR));
    chk(req, "bkpt", 32'(bkpt), 32'(eBk));
    chk(req, "bkptHalf", 32'(bkptHalf), 32'(eHalf));
    if (eIfV) chk(req, "ifOutAddr", ifOutAddr, eIfA);
    chk(req, "litOutValid", 32'(litOutValid), 32'(eLitV));
    chk(req, "litRemap", 32'(litRemap), 32'(eLitR));
    if (eLitV) chk(req, "litOutAddr", litOutAddr, eLitA);
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    shadowReset();
    rst = 1; cfgWe = 0; cfgSel = 0; cfgWdata = 0;
    ifValid = 0; ifAddr = 0; litValid = 0; litAddr = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "ifOutValid", 32'(ifOutValid), 0);
    chk("R1", "bkpt", 32'(bkpt), 0);
    chk("R1", "litRemap", 32'(litRemap), 0);
    rst = 0;
    step(1, 32'h0, 1, 32'h0, "R1");
    wr(0, 32'h1);
    step(1, 32'h0, 1, 32'h0, "R1");

    wr(1, 32'h2000_1000);
    wr(2, slot(2'b00, 32'h400, 1));
    step(1, 32'h402, 0, 0, "R3");
    chk("R3", "direct target", ifOutAddr, 32'h2000_1002);

    wr(0, 32'h0);
    step(1, 32'h400, 0, 0, "R2");
    wr(0, 32'h1);

    wr(3, slot(2'b10, 32'h800, 1));
    step(1, 32'h800, 0, 0, "R4");
    chk("R4", "half upper", 32'(bkptHalf), 32'h2);
    wr(3, slot(2'b01, 32'h800, 1));
    step(1, 32'h801, 0, 0, "R4");
    wr(3, slot(2'b11, 32'h800, 1));
    step(1, 32'h803, 0, 0, "R4");

    wr(4, slot(2'b11, 32'hC00, 1));
    wr(5, slot(2'b00, 32'hC00, 1));
    step(1, 32'hC00, 0, 0, "R8");
    chk("R8", "bp wins", 32'(bkpt), 1);
    wr(6, slot(2'b00, 32'h1000, 1));
    wr(7, slot(2'b01, 32'h1000, 1));
    step(1, 32'h1001, 0, 0, "R8");
    chk("R8", "remap idx4", ifOutAddr, 32'h2000_1011);

    wr(8, slot(2'b11, 32'h2000, 1));
    wr(9, slot(2'b00, 32'h2000, 1));
    step(0, 0, 1, 32'h2001, "R5");
    chk("R5", "lit idx6", litOutAddr, 32'h2000_1019);
    step(1, 32'h2000, 1, 32'h400, "R6");

    step(1, 32'h2000_0400, 1, 32'hE000_2000, "R7");
    step(0, 32'h400, 0, 32'h2000, "R9");

    wr(2, slot(2'b00, 32'h400, 0));
    step(1, 32'h400, 0, 0, "R10");
    wr(12, 32'hFFFF_FFFF);
    wr(15, 32'h0);
    step(1, 32'h800, 1, 32'h2000, "R10");

    for (int n = 0; n < 600; n++) begin
      if ($urandom % 4 == 0) begin
        logic [3:0]  sel;
        logic [31:0] a;
        sel = 4'($urandom % 16);
        a = {3'b000, 27'h40 + 27'($urandom % 4), 2'b00};
        if (sel == 0) wr(sel, ($urandom % 8 == 0) ? 32'h0 : 32'h1);
        else if (sel == 1) wr(sel, $urandom);
        else wr(sel, slot(2'($urandom), a, ($urandom % 5) != 0));
      end else begin
        logic [31:0] ia, la;
        ia = {3'b000, 27'h40 + 27'($urandom % 4), 2'($urandom)};
        la = {3'b000, 27'h40 + 27'($urandom % 4), 2'($urandom)};
        if ($urandom % 6 == 0) ia[31:29] = 3'($urandom % 7 + 1);
        if ($urandom % 6 == 0) la[31:29] = 3'($urandom % 7 + 1);
        step(($urandom % 5) != 0, ia, ($urandom % 3) != 0, la, "R8");
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule